// File: doc/BRIEF.md
# Interrupt Moderation and Delay Controller

This block sits between the event sources of a network receive and transmit datapath and the interrupt line of a host. Each event arrives as a pulse on one bit of a cause vector. The pulses build up in a sticky cause register, and the register stays set until a read-to-clear strobe empties it. The block then decides when the host should see an interrupt. A throttle interval sets a minimum gap between two deliveries. The gap is measured from the last delivery, so a cause that arrives after a long quiet period goes out at once. A cause that arrives too early is held back until the gap has run out. An urgent flag on a cause skips the throttle.

Two delay timers act on receive traffic. The per-packet timer starts again on every completed packet. The absolute timer starts on the first completed packet and is not started again while it runs. It runs whatever value the per-packet timer has. When either timer expires it posts the receive cause through the throttle, and it stops the other timer. When both delays are zero, a completed packet posts the receive cause at once.

All time is kept in units of 256 ns. One unit is `TICKS_PER_UNIT` clock cycles, which is 32 cycles at 125 MHz. The time since the last delivery is held as a saturating age counter. That counter can be read out and loaded back, so it can be saved and restored.

Top module: `intmod_top`

## Requirements
- R1: Every pulse on `causeIn` is ORed into `causeOut` in the edge that samples it. Set bits stay set until `clearIn` is sampled. A clear zeroes the register, except for bits that are posted in the same cycle, which survive. `causeOut` is 0 after reset.
- R2: `ageOut` counts time units. It rises by one every `TICKS_PER_UNIT` clock cycles and stops at the saturation value 2^`ITR_W`.
- R3: A posted cause is delivered at once in three cases:
  - `itrInterval` is 0;
  - `urgentIn` is high while a cause is posted;
  - `ageOut` is at least `itrInterval`.
  A delivery is a one-cycle pulse on `irqOut`, in the cycle after the edge that sampled the cause. Each delivery resets the age to 0.
- R4: In all other cases the delivery is deferred. The deferred pulse appears when the age, counted from the last delivery, reaches `itrInterval`. It is not timed from the moment the cause was posted.
- R5: While a deferred delivery is pending, further causes neither restart it nor move it. The pending delivery produces exactly one pulse.
- R6: An immediate delivery cancels a pending deferred delivery, so no second pulse follows.
- R7: A sampled `rxDoneIn` with `absDelay` nonzero starts the absolute timer for `absDelay` units, but only if that timer is not already running. The per-packet delay plays no part in this.
- R8: A sampled `rxDoneIn` with `pktDelay` nonzero restarts the per-packet timer for `pktDelay` units.
- R9: A completed packet posts the receive cause (bit `RX_BIT`, default bit 0) at once only when `pktDelay` and `absDelay` are both 0. Otherwise completion sets no cause bit.
- R10: When either delay timer expires, it posts the receive cause bit through the throttling rules of R3 and R4. The expiry also stops the other timer, so one burst gives exactly one interrupt.
- R11: After reset the age is saturated, so the first cause is delivered at once. `ageLoadIn` loads `ageLoadVal` into the age, the loaded value reads back on `ageOut`, and it is used for the following throttle decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeIn | input | NCAUSE | Cause pulses, one bit per event class |
| urgentIn | input | 1 | Deliver the causes posted in this cycle without throttling |
| rxDoneIn | input | 1 | Receive packet completion strobe |
| clearIn | input | 1 | Read-to-clear strobe for the cause register |
| itrInterval | input | ITR_W | Minimum gap between deliveries, in 256 ns units |
| pktDelay | input | DLY_W | Per-packet receive delay, in units |
| absDelay | input | DLY_W | Absolute receive delay, in units |
| ageLoadIn | input | 1 | Load the age counter (restore) |
| ageLoadVal | input | ITR_W+1 | Age value to restore |
| irqOut | output | 1 | One-cycle interrupt delivery pulse |
| causeOut | output | NCAUSE | Cause register contents |
| ageOut | output | ITR_W+1 | Units since the last delivery, saturating (save) |

## Verification
The bench checks the following corner cases:
- A cause is posted part-way through the throttle gap. A design that timed the deferral from the post would fire about ten cycles too late.
- A second cause arrives while one is already pending. A design that moved or restarted the pending delivery would shift the pulse or emit two.
- An urgent cause lands on top of a pending deferral. A design that kept the deferral would give a second, stray pulse.
- The absolute delay is set and the per-packet delay is zero, and packets keep arriving. A design that tied the absolute timer to the per-packet delay would post the receive cause at once. A design that restarted the absolute timer on every packet would deliver late.
- Both timers are armed. A design that did not stop the other timer would interrupt twice.
- A restored age is used for throttling. A design that ignored the loaded value would deliver when it should defer.

// File: rtl/intmod_pkg.sv
package intmod_pkg;
  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic deliver;    // interrupt goes out this cycle
    logic rxPost;     // receive cause bit is posted this cycle
    logic pktLoad;    // restart per-packet timer
    logic absLoad;    // start absolute timer
    logic timerStop;  // a timer expired: stop both
  } ctlStrobes_t;
endpackage

// File: rtl/intmod_dlytimer.sv
module intmod_dlytimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         stop,
  output logic         expire,
  output logic         running
);
  logic [W-1:0] cnt;

  assign running = (cnt != '0);
  assign expire  = tick && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (load)         cnt <= loadVal;
    else if (stop)         cnt <= '0;
    else if (tick && running) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/intmod_datapath.sv
module intmod_datapath
  import intmod_pkg::*;
#(
  parameter int NCAUSE         = 8,
  parameter int RX_BIT         = 0,
  parameter int ITR_W          = 16,
  parameter int DLY_W          = 16,
  parameter int TICKS_PER_UNIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [NCAUSE-1:0] causeIn,
  input  logic              clearIn,
  input  logic [ITR_W-1:0]  itrInterval,
  input  logic [DLY_W-1:0]  pktDelay,
  input  logic [DLY_W-1:0]  absDelay,
  input  logic              ageLoadIn,
  input  logic [ITR_W:0]    ageLoadVal,
  output logic              ageReady,
  output logic              pktExpire,
  output logic              absExpire,
  output logic              absRunning,
  output logic              irqOut,
  output logic [NCAUSE-1:0] causeOut,
  output logic [ITR_W:0]    ageOut
);
  localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);
  localparam int AGE_W = ITR_W + 1;
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(1) << ITR_W;
  localparam int NTMR = 2;  // index 0: per-packet, 1: absolute

  // Time base: one unit tick per 256 ns
  logic [PRE_W-1:0] presc;
  logic unitTick;
  assign unitTick = (presc == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)         presc <= '0;
    else if (unitTick) presc <= '0;
    else               presc <= presc + PRE_W'(1);
  end

  // Age since last delivery, saturating
  logic [AGE_W-1:0] age;
  always_ff @(posedge clk) begin
    if (!rstN)                            age <= AGE_SAT;
    else if (ageLoadIn)                   age <= ageLoadVal;
    else if (ctl.deliver)                 age <= '0;
    else if (unitTick && age < AGE_SAT)   age <= age + AGE_W'(1);
  end
  assign ageReady = (age >= AGE_W'(itrInterval));
  assign ageOut   = age;

  // Receive delay timers
  logic [NTMR-1:0] tLoad, tExp, tRun;
  logic [DLY_W-1:0] tVal [NTMR];
  assign tLoad = {ctl.absLoad, ctl.pktLoad};
  assign tVal[0] = pktDelay;
  assign tVal[1] = absDelay;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    intmod_dlytimer #(.W(DLY_W)) u_tmr (
      .clk(clk), .rstN(rstN), .tick(unitTick), .load(tLoad[g]),
      .loadVal(tVal[g]), .stop(ctl.timerStop),
      .expire(tExp[g]), .running(tRun[g])
    );
  end
  assign pktExpire  = tExp[0];
  assign absExpire  = tExp[1];
  assign absRunning = tRun[1];

  // Sticky cause register
  logic [NCAUSE-1:0] causeReg, newCause;
  assign newCause = causeIn | (ctl.rxPost ? (NCAUSE'(1) << RX_BIT) : '0);
  always_ff @(posedge clk) begin
    if (!rstN) causeReg <= '0;
    else       causeReg <= (clearIn ? '0 : causeReg) | newCause;
  end
  assign causeOut = causeReg;

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= ctl.deliver;
  end

  // R1: bits never drop without a clear
  p_cause_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    !clearIn |=> ((causeReg & $past(causeReg)) == $past(causeReg)));
  // R4: the throttle gap is measured from each delivery
  p_age_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.deliver && !ageLoadIn) |=> (age == '0));
  // R7: absolute timer never restarted while running
  p_abs_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.absLoad |-> !tRun[1]);
  // R10: expiry stops the other timer
  p_stop_pkt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.timerStop && !ctl.pktLoad) |=> !tRun[0]);
  p_stop_abs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.timerStop && !ctl.absLoad) |=> !tRun[1]);
endmodule

// File: rtl/intmod_control.sv
module intmod_control
  import intmod_pkg::*;
#(
  parameter int NCAUSE = 8,
  parameter int ITR_W  = 16,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCAUSE-1:0] causeIn,
  input  logic              urgentIn,
  input  logic              rxDoneIn,
  input  logic [ITR_W-1:0]  itrInterval,
  input  logic [DLY_W-1:0]  pktDelay,
  input  logic [DLY_W-1:0]  absDelay,
  input  logic              ageReady,
  input  logic              pktExpire,
  input  logic              absExpire,
  input  logic              absRunning,
  output ctlStrobes_t       ctl
);
  logic pending;
  logic immRx, tmrRx, rxPost, postAny, itrZero, readyNow, pendFire, deliver;

  always_comb begin
    immRx    = rxDoneIn && (pktDelay == '0) && (absDelay == '0);
    tmrRx    = pktExpire || absExpire;
    rxPost   = immRx || tmrRx;
    postAny  = (causeIn != '0) || rxPost;
    itrZero  = (itrInterval == '0);
    readyNow = itrZero || urgentIn || ageReady;
    pendFire = pending && (itrZero || ageReady);
    deliver  = (postAny && readyNow) || pendFire;

    ctl.deliver   = deliver;
    ctl.rxPost    = rxPost;
    ctl.pktLoad   = rxDoneIn && (pktDelay != '0);
    ctl.absLoad   = rxDoneIn && (absDelay != '0) && !absRunning;
    ctl.timerStop = tmrRx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        pending <= 1'b0;
    else if (deliver) pending <= 1'b0;
    else if (postAny) pending <= 1'b1;
  end

  // R4: a deferral only arises under a nonzero interval without urgency
  p_defer_needs_throttle_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> ($past(itrInterval) != '0) && !$past(urgentIn));
endmodule

// File: rtl/intmod_top.sv
module intmod_top
  import intmod_pkg::*;
#(
  parameter int NCAUSE         = 8,
  parameter int RX_BIT         = 0,
  parameter int ITR_W          = 16,
  parameter int DLY_W          = 16,
  parameter int TICKS_PER_UNIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCAUSE-1:0] causeIn,
  input  logic              urgentIn,
  input  logic              rxDoneIn,
  input  logic              clearIn,
  input  logic [ITR_W-1:0]  itrInterval,
  input  logic [DLY_W-1:0]  pktDelay,
  input  logic [DLY_W-1:0]  absDelay,
  input  logic              ageLoadIn,
  input  logic [ITR_W:0]    ageLoadVal,
  output logic              irqOut,
  output logic [NCAUSE-1:0] causeOut,
  output logic [ITR_W:0]    ageOut
);
  ctlStrobes_t ctl;
  logic ageReady, pktExpire, absExpire, absRunning;

  intmod_control #(.NCAUSE(NCAUSE), .ITR_W(ITR_W), .DLY_W(DLY_W)) u_ctl (
    .clk(clk), .rstN(rstN), .causeIn(causeIn), .urgentIn(urgentIn),
    .rxDoneIn(rxDoneIn), .itrInterval(itrInterval), .pktDelay(pktDelay),
    .absDelay(absDelay), .ageReady(ageReady), .pktExpire(pktExpire),
    .absExpire(absExpire), .absRunning(absRunning), .ctl(ctl)
  );

  intmod_datapath #(.NCAUSE(NCAUSE), .RX_BIT(RX_BIT), .ITR_W(ITR_W),
                    .DLY_W(DLY_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .causeIn(causeIn), .clearIn(clearIn),
    .itrInterval(itrInterval), .pktDelay(pktDelay), .absDelay(absDelay),
    .ageLoadIn(ageLoadIn), .ageLoadVal(ageLoadVal), .ageReady(ageReady),
    .pktExpire(pktExpire), .absExpire(absExpire), .absRunning(absRunning),
    .irqOut(irqOut), .causeOut(causeOut), .ageOut(ageOut)
  );

  // R3: an urgent cause goes out on the next cycle
  p_urgent_now_r3: assert property (@(posedge clk) disable iff (!rstN)
    (urgentIn && causeIn != '0) |=> irqOut);
endmodule

// File: tb/test_intmod_top.sv
module test_intmod_top;
  localparam int TPU = 4;
  localparam int ITR_W = 16;
  localparam int DLY_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] causeIn = '0;
  logic urgentIn = 1'b0, rxDoneIn = 1'b0, clearIn = 1'b0, ageLoadIn = 1'b0;
  logic [ITR_W-1:0] itrInterval = '0;
  logic [DLY_W-1:0] pktDelay = '0, absDelay = '0;
  logic [ITR_W:0] ageLoadVal = '0;
  logic irqOut;
  logic [7:0] causeOut;
  logic [ITR_W:0] ageOut;

  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  intmod_top #(.NCAUSE(8), .RX_BIT(0), .ITR_W(ITR_W), .DLY_W(DLY_W),
               .TICKS_PER_UNIT(TPU)) i_intmod_top (
    .clk(clk), .rstN(rstN), .causeIn(causeIn), .urgentIn(urgentIn),
    .rxDoneIn(rxDoneIn), .clearIn(clearIn), .itrInterval(itrInterval),
    .pktDelay(pktDelay), .absDelay(absDelay), .ageLoadIn(ageLoadIn),
    .ageLoadVal(ageLoadVal), .irqOut(irqOut), .causeOut(causeOut), .ageOut(ageOut)
  );

  // {cause[18:11], urgent[10], clear[9], expIrq[8], expCause[7:0]}, interval 0
  localparam logic [18:0] VEC [0:7] = '{
    {8'h01, 1'b0, 1'b0, 1'b1, 8'h01},
    {8'h04, 1'b0, 1'b0, 1'b1, 8'h05},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h05},
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h80, 1'b0, 1'b1, 1'b1, 8'h80},
    {8'h80, 1'b1, 1'b0, 1'b1, 8'h80},
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h12, 1'b0, 1'b0, 1'b1, 8'h12}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input longint act, input longint lo, input longint hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Inputs set at a falling edge, sampled one rising edge later
  task automatic step(input logic [7:0] c, input logic u, input logic clr,
                      input logic rx, input logic ld, input logic [ITR_W:0] ldv);
    causeIn = c; urgentIn = u; clearIn = clr; rxDoneIn = rx;
    ageLoadIn = ld; ageLoadVal = ldv;
    @(negedge clk);
    causeIn = '0; urgentIn = 1'b0; clearIn = 1'b0; rxDoneIn = 1'b0; ageLoadIn = 1'b0;
  endtask

  // Watch n edges; inject the stimulus on the edges whose bit is set in mask
  task automatic watch(input int n, input logic [63:0] mask, input logic [7:0] c,
                       input logic u, input logic rx, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      causeIn  = mask[i] ? c : 8'h00;
      urgentIn = mask[i] ? u : 1'b0;
      rxDoneIn = mask[i] ? rx : 1'b0;
      @(negedge clk);
      if (irqOut) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    causeIn = '0; urgentIn = 1'b0; rxDoneIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int cnt, first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 / R11: reset state
    chk("R1 reset cause", causeOut, 0);
    chk("R3 reset irq", irqOut, 0);
    chk("R11 reset age saturated", ageOut, 65536);

    // R1 / R3: vector table with interval 0
    for (int v = 0; v < 8; v++) begin
      step(VEC[v][18:11], VEC[v][10], VEC[v][9], 1'b0, 1'b0, '0);
      chk($sformatf("R3 vec%0d irq", v), irqOut, VEC[v][8]);
      chk($sformatf("R1 vec%0d cause", v), causeOut, VEC[v][7:0]);
    end

    // R4 / R5: deferral timed from the last delivery, not moved by later causes
    itrInterval = 16'd5;
    repeat (30) @(negedge clk);
    step(8'h02, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R3 idle past interval delivers at once", irqOut, 1);
    watch(40, (64'd1 << 10) | (64'd1 << 14), 8'h02, 1'b0, 1'b0, cnt, first);
    chk("R5 one deferred pulse", cnt, 1);
    chkRange("R4 deferred time from last delivery", first, 17, 22);

    // R3: age past interval gives immediate delivery
    repeat (30) @(negedge clk);
    step(8'h08, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R3 age elapsed immediate", irqOut, 1);

    // R6: urgent cancels the pending deferral
    watch(3, 64'd1 << 3, 8'h08, 1'b0, 1'b0, cnt, first);
    chk("R4 early cause deferred", cnt, 0);
    step(8'h20, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R3 urgent immediate", irqOut, 1);
    watch(40, 64'd0, 8'h00, 1'b0, 1'b0, cnt, first);
    chk("R6 no pulse after cancel", cnt, 0);

    // Receive path, interval 0
    itrInterval = '0;
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R9 both delays zero irq", irqOut, 1);
    chk("R9 both delays zero cause", causeOut, 8'h01);

    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    pktDelay = 16'd3;
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R9 delayed no immediate irq", irqOut, 0);
    chk("R9 delayed no immediate cause", causeOut, 0);
    watch(20, 64'd0, 8'h00, 1'b0, 1'b0, cnt, first);
    chk("R10 pkt expiry one pulse", cnt, 1);
    chk("R10 expiry posts rx bit", causeOut, 8'h01);

    watch(30, (64'd1 << 1) | (64'd1 << 7), 8'h00, 1'b0, 1'b1, cnt, first);
    chk("R8 restart one pulse", cnt, 1);
    chkRange("R8 restart timing", first, 15, 20);

    pktDelay = '0; absDelay = 16'd4;
    watch(30, 64'd1 << 1, 8'h00, 1'b0, 1'b1, cnt, first);
    chk("R7 abs alone one pulse", cnt, 1);
    chkRange("R7 abs alone timing", first, 13, 18);

    watch(30, (64'd1 << 1) | (64'd1 << 7), 8'h00, 1'b0, 1'b1, cnt, first);
    chkRange("R7 abs not restarted", first, 13, 18);

    pktDelay = 16'd3;
    watch(45, (64'd1 << 1) | (64'd1 << 7) | (64'd1 << 13), 8'h00, 1'b0, 1'b1, cnt, first);
    chk("R10 abs beats repeating pkt one pulse", cnt, 1);
    chkRange("R7 abs runs with pkt delay set", first, 13, 18);

    pktDelay = 16'd2; absDelay = 16'd6;
    watch(40, 64'd1 << 1, 8'h00, 1'b0, 1'b1, cnt, first);
    chk("R10 other timer stopped", cnt, 1);
    chkRange("R10 pkt expiry timing", first, 5, 10);
    pktDelay = '0; absDelay = '0;

    // R11 / R2: restore the age
    itrInterval = 16'd5;
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 17'd0);
    chk("R11 loaded age reads back", ageOut, 0);
    step(8'h04, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R11 restored age throttles", irqOut, 0);
    watch(40, 64'd0, 8'h00, 1'b0, 1'b0, cnt, first);
    chk("R11 deferred after restore", cnt, 1);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 17'd200);
    step(8'h04, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R11 restored old age delivers", irqOut, 1);

    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 17'd0);
    repeat (40) @(negedge clk);
    chkRange("R2 age counts units", ageOut, 9, 10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule